// File: doc/BRIEF.md
# Segment Base and Linear Address Unit

This unit keeps three base registers for a 64-bit core that can also execute 32-bit compatibility code: the FS base, the GS base and a kernel shadow copy of the GS base. The bases change in three ways. A descriptor-style segment load supplies a 32-bit base. A privileged register write supplies a full 64-bit base. A swap request exchanges the GS base with the kernel shadow.

For every memory access the unit forms the linear address from the selected segment, the current mode, an index and a displacement. It reports the address one cycle later, together with a two-bit fault code. In 64-bit mode the unit checks for canonical form in place of a segment limit. Descriptor fetch, legacy limit and attribute checks, paging and the privilege source all sit outside this block and arrive as plain inputs.

Top module: `seg_lin_unit`

## Requirements
- R1: After reset the FS, GS and kernel shadow bases are zero, and `rsp_valid` is low until a request is seen.
- R2: In 64-bit mode (`mode64`=1), the segment codes ES=0, CS=1, SS=2 and DS=3 use a base of zero whatever `leg_base` holds, so the address is index+displacement modulo 2^64.
- R3: In 64-bit mode, an access with FS (code 4) or GS (code 5) produces base+index+displacement modulo 2^64. The sum wraps between positive and negative addresses.
- R4: In 64-bit mode, a linear address whose bits 63 down to 47 are not all equal sets `rsp_code` bit 0 (non-canonical access). No limit check is applied.
- R5: A segment load (`seg_ld_valid`, with `seg_ld_sel` 0=FS and 1=GS) writes `seg_ld_base` into bits 31:0 of the target and clears bits 63:32.
- R6: A privileged write (`msr_wr_valid`, with `msr_wr_sel` 0=FS, 1=GS, 2=kernel shadow) loads all 64 bits only when `cpl`==0, the value is canonical and the selector is not 3. Otherwise it sets `rsp_code` bit 1 and changes no register.
- R7: When `mode64`=1, a swap request exchanges the GS base and the kernel shadow in one cycle. When `mode64`=0 the swap request is ignored.
- R8: In compatibility mode (`mode64`=0), the address is (base[31:0]+index[31:0]+disp[31:0]) modulo 2^32, zero-extended, and never faults. FS and GS take their base from the stored registers; the other codes take it from `leg_base`.
- R9: Changing `mode64` never alters a stored base.
- R10: When update requests coincide, a swap that takes effect wins over a privileged write, and a privileged write wins over a segment load. A request that loses has no effect and produces no response.
- R11: `rsp_valid` rises one cycle after `acc_valid` or after a privileged write that takes effect. `rsp_code` bit 0 is the access fault and bit 1 is the write rejection, and both may be set together. An access in the same cycle as an update sees the bases as they were before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 = 64-bit mode, 0 = compatibility mode |
| cpl | input | 2 | Current privilege level |
| seg_ld_valid | input | 1 | Descriptor-style base load request |
| seg_ld_sel | input | 1 | Load target: 0 = FS, 1 = GS |
| seg_ld_base | input | 32 | 32-bit base from the descriptor |
| msr_wr_valid | input | 1 | Privileged base write request |
| msr_wr_sel | input | 2 | Write target: 0 = FS, 1 = GS, 2 = kernel shadow, 3 = invalid |
| msr_wr_data | input | 64 | Value to write |
| swap_req | input | 1 | Exchange GS base with the kernel shadow |
| acc_valid | input | 1 | Address request |
| acc_seg | input | 3 | Segment code: 0 ES, 1 CS, 2 SS, 3 DS, 4 FS, 5 GS |
| acc_index | input | 64 | Index term |
| acc_disp | input | 64 | Displacement term |
| leg_base | input | 32 | Base for the other segments in compatibility mode |
| rsp_valid | output | 1 | Response valid |
| rsp_fault | output | 1 | Any fault in `rsp_code` |
| rsp_code | output | 2 | Bit 0 = non-canonical access, bit 1 = rejected write |
| rsp_addr | output | 64 | Linear address (zero when no access was made) |

## Verification
An address request and a base update can arrive in the same cycle, and both feed the single response register. The bench provokes this by issuing an access together with a rejected privileged write, and expects code 3 along with the correct address. It also issues a GS access together with a swap or a successful write, and expects the address to be built from the base as it stood before the update, while the new base shows up on the next access. The bench also collides a swap, a write and a load, and judges each register through later reads.

// File: rtl/seg_lin_pkg.sv
package seg_lin_pkg;
   typedef enum logic [2:0] {
      SEG_ES = 3'd0,
      SEG_CS = 3'd1,
      SEG_SS = 3'd2,
      SEG_DS = 3'd3,
      SEG_FS = 3'd4,
      SEG_GS = 3'd5
   } seg_sel_e;

   typedef enum logic [1:0] {
      BR_FS  = 2'd0,
      BR_GS  = 2'd1,
      BR_KGS = 2'd2,
      BR_BAD = 2'd3
   } base_sel_e;

   localparam int CODE_ACC_BIT = 0;
   localparam int CODE_WR_BIT  = 1;
endpackage

// File: rtl/seg_canon_chk.sv
module seg_canon_chk #(
   parameter int VA_W = 64,
   parameter int LA_W = 48,
   localparam int HI_W = VA_W - LA_W + 1
) (
   input  logic [HI_W-1:0] hi_bits,
   output logic            canon
);
   generate
      if (LA_W >= VA_W) begin : g_full
         assign canon = 1'b1;
      end else begin : g_slice
         assign canon = (&hi_bits) | ~(|hi_bits);
      end
   endgenerate
endmodule

// File: rtl/seg_base_regs.sv
module seg_base_regs #(
   parameter int VA_W = 64,
   parameter int LA_W = 48,
   parameter int SL_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode64,
   input  logic [1:0]      cpl,
   input  logic            seg_ld_valid,
   input  logic            seg_ld_sel,
   input  logic [SL_W-1:0] seg_ld_base,
   input  logic            msr_wr_valid,
   input  logic [1:0]      msr_wr_sel,
   input  logic [VA_W-1:0] msr_wr_data,
   input  logic            swap_req,
   output logic [VA_W-1:0] fs_base,
   output logic [VA_W-1:0] gs_base,
   output logic [VA_W-1:0] kgs_base,
   output logic            wr_done,
   output logic            wr_reject
);
   import seg_lin_pkg::*;

   logic [VA_W-1:0] fs_q, gs_q, kgs_q;
   logic            do_swap, do_wr, do_ld, wr_ok, data_canon;
   logic [VA_W-1:0] ld_ext;

   seg_canon_chk #(.VA_W(VA_W), .LA_W(LA_W)) u_wr_canon (
      .hi_bits (msr_wr_data[VA_W-1:LA_W-1]),
      .canon   (data_canon)
   );

   assign ld_ext  = {{(VA_W-SL_W){1'b0}}, seg_ld_base};
   assign do_swap = swap_req & mode64;
   assign do_wr   = msr_wr_valid & ~do_swap;
   assign do_ld   = seg_ld_valid & ~do_swap & ~msr_wr_valid;
   assign wr_ok   = do_wr & (cpl == 2'd0) & data_canon & (msr_wr_sel != BR_BAD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fs_q  <= '0;
         gs_q  <= '0;
         kgs_q <= '0;
      end else if (do_swap) begin
         gs_q  <= kgs_q;
         kgs_q <= gs_q;
      end else if (wr_ok) begin
         unique case (msr_wr_sel)
            BR_FS:   fs_q  <= msr_wr_data;
            BR_GS:   gs_q  <= msr_wr_data;
            BR_KGS:  kgs_q <= msr_wr_data;
            default: ;
         endcase
      end else if (do_ld) begin
         if (seg_ld_sel) gs_q <= ld_ext;
         else            fs_q <= ld_ext;
      end
   end

   assign fs_base   = fs_q;
   assign gs_base   = gs_q;
   assign kgs_base  = kgs_q;
   assign wr_done   = do_wr;
   assign wr_reject = do_wr & ~wr_ok;

   // R7: one-cycle exchange
   p_swap_exchange_r7: assert property (@(posedge clk) disable iff (!rst_n)
      swap_req && mode64 |=> (gs_q == $past(kgs_q)) && (kgs_q == $past(gs_q)));

   // R10: a taking swap blocks every other update of FS
   p_swap_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
      swap_req && mode64 |=> fs_q == $past(fs_q));

   // R6: unprivileged write leaves all bases untouched
   p_reject_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      msr_wr_valid && !(swap_req && mode64) && cpl != 2'd0
      |=> $stable(fs_q) && $stable(gs_q) && $stable(kgs_q));

   // R5: a lone segment load leaves the upper bits clear
   p_load_upper_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
      seg_ld_valid && !msr_wr_valid && !(swap_req && mode64)
      |=> ($past(seg_ld_sel) ? gs_q[VA_W-1:SL_W] : fs_q[VA_W-1:SL_W]) == '0);

   // R9: without an update request nothing moves, whatever mode does
   p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_ld_valid && !msr_wr_valid && !(swap_req && mode64)
      |=> $stable(fs_q) && $stable(gs_q) && $stable(kgs_q));
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen #(
   parameter int VA_W = 64,
   parameter int LA_W = 48,
   parameter int CW   = 32
) (
   input  logic            mode64,
   input  logic [2:0]      acc_seg,
   input  logic [VA_W-1:0] acc_index,
   input  logic [VA_W-1:0] acc_disp,
   input  logic [CW-1:0]   leg_base,
   input  logic [VA_W-1:0] fs_base,
   input  logic [VA_W-1:0] gs_base,
   output logic [VA_W-1:0] lin_addr,
   output logic            non_canon
);
   import seg_lin_pkg::*;

   logic [VA_W-1:0] base_sel, sum_wide;
   logic [CW-1:0]   sum_narrow;
   logic            sum_canon;

   always_comb begin
      if (acc_seg == SEG_FS)      base_sel = fs_base;
      else if (acc_seg == SEG_GS) base_sel = gs_base;
      else if (mode64)            base_sel = '0;
      else                        base_sel = {{(VA_W-CW){1'b0}}, leg_base};
   end

   assign sum_wide   = base_sel + acc_index + acc_disp;
   assign sum_narrow = base_sel[CW-1:0] + acc_index[CW-1:0] + acc_disp[CW-1:0];

   seg_canon_chk #(.VA_W(VA_W), .LA_W(LA_W)) u_acc_canon (
      .hi_bits (sum_wide[VA_W-1:LA_W-1]),
      .canon   (sum_canon)
   );

   assign lin_addr  = mode64 ? sum_wide : {{(VA_W-CW){1'b0}}, sum_narrow};
   assign non_canon = mode64 & ~sum_canon;
endmodule

// File: rtl/seg_lin_unit.sv
module seg_lin_unit #(
   parameter int VA_W = 64,
   parameter int LA_W = 48,
   parameter int CW   = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            mode64,
   input  logic [1:0]      cpl,
   input  logic            seg_ld_valid,
   input  logic            seg_ld_sel,
   input  logic [CW-1:0]   seg_ld_base,
   input  logic            msr_wr_valid,
   input  logic [1:0]      msr_wr_sel,
   input  logic [VA_W-1:0] msr_wr_data,
   input  logic            swap_req,
   input  logic            acc_valid,
   input  logic [2:0]      acc_seg,
   input  logic [VA_W-1:0] acc_index,
   input  logic [VA_W-1:0] acc_disp,
   input  logic [CW-1:0]   leg_base,
   output logic            rsp_valid,
   output logic            rsp_fault,
   output logic [1:0]      rsp_code,
   output logic [VA_W-1:0] rsp_addr
);
   import seg_lin_pkg::*;

   generate
      if (LA_W <= CW || LA_W > VA_W) begin : g_bad_la
         $error("LA_W must lie above CW and not exceed VA_W");
      end
      if (CW >= VA_W) begin : g_bad_cw
         $error("CW must be narrower than VA_W");
      end
   endgenerate

   logic [VA_W-1:0] fs_b, gs_b, kgs_b, lin;
   logic            wr_done, wr_reject, nc;
   logic            vld_q;
   logic [1:0]      code_q;
   logic [VA_W-1:0] addr_q;

   seg_base_regs #(.VA_W(VA_W), .LA_W(LA_W), .SL_W(CW)) u_regs (
      .clk          (clk),
      .rst_n        (rst_n),
      .mode64       (mode64),
      .cpl          (cpl),
      .seg_ld_valid (seg_ld_valid),
      .seg_ld_sel   (seg_ld_sel),
      .seg_ld_base  (seg_ld_base),
      .msr_wr_valid (msr_wr_valid),
      .msr_wr_sel   (msr_wr_sel),
      .msr_wr_data  (msr_wr_data),
      .swap_req     (swap_req),
      .fs_base      (fs_b),
      .gs_base      (gs_b),
      .kgs_base     (kgs_b),
      .wr_done      (wr_done),
      .wr_reject    (wr_reject)
   );

   seg_addr_gen #(.VA_W(VA_W), .LA_W(LA_W), .CW(CW)) u_addr (
      .mode64    (mode64),
      .acc_seg   (acc_seg),
      .acc_index (acc_index),
      .acc_disp  (acc_disp),
      .leg_base  (leg_base),
      .fs_base   (fs_b),
      .gs_base   (gs_b),
      .lin_addr  (lin),
      .non_canon (nc)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q  <= 1'b0;
         code_q <= 2'b00;
         addr_q <= '0;
      end else begin
         vld_q                <= acc_valid | wr_done;
         code_q[CODE_ACC_BIT] <= acc_valid & nc;
         code_q[CODE_WR_BIT]  <= wr_reject;
         addr_q               <= acc_valid ? lin : '0;
      end
   end

   assign rsp_valid = vld_q;
   assign rsp_code  = code_q;
   assign rsp_fault = |code_q;
   assign rsp_addr  = addr_q;

   // R11: every access is answered in the following cycle
   p_acc_answer_r11: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid |=> rsp_valid);

   // R8: compatibility results fit in 32 bits and never fault on access
   p_compat_narrow_r8: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && !mode64 |=> rsp_addr[VA_W-1:CW] == '0 && !rsp_code[CODE_ACC_BIT]);

   // R4: fault bit agrees with the reported address shape
   p_canon_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
      acc_valid && mode64 |=> rsp_code[CODE_ACC_BIT] ==
         !((&rsp_addr[VA_W-1:LA_W-1]) || !(|rsp_addr[VA_W-1:LA_W-1])));

   // R1: no response out of reset without a request
   p_fault_needs_valid_r1: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_fault |-> rsp_valid);
endmodule

// File: tb/seg_lin_unit_bench.sv
`timescale 1ns/1ps
module seg_lin_unit_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        mode64 = 1'b1;
   logic [1:0]  cpl = 2'd0;
   logic        seg_ld_valid = 1'b0;
   logic        seg_ld_sel = 1'b0;
   logic [31:0] seg_ld_base = '0;
   logic        msr_wr_valid = 1'b0;
   logic [1:0]  msr_wr_sel = 2'd0;
   logic [63:0] msr_wr_data = '0;
   logic        swap_req = 1'b0;
   logic        acc_valid = 1'b0;
   logic [2:0]  acc_seg = 3'd0;
   logic [63:0] acc_index = '0;
   logic [63:0] acc_disp = '0;
   logic [31:0] leg_base = '0;
   logic        rsp_valid, rsp_fault;
   logic [1:0]  rsp_code;
   logic [63:0] rsp_addr;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   seg_lin_unit u_seg_lin_unit (
      .clk(clk), .rst_n(rst_n), .mode64(mode64), .cpl(cpl),
      .seg_ld_valid(seg_ld_valid), .seg_ld_sel(seg_ld_sel), .seg_ld_base(seg_ld_base),
      .msr_wr_valid(msr_wr_valid), .msr_wr_sel(msr_wr_sel), .msr_wr_data(msr_wr_data),
      .swap_req(swap_req), .acc_valid(acc_valid), .acc_seg(acc_seg),
      .acc_index(acc_index), .acc_disp(acc_disp), .leg_base(leg_base),
      .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_code(rsp_code), .rsp_addr(rsp_addr)
   );

   task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic idle();
      seg_ld_valid = 0; msr_wr_valid = 0; swap_req = 0; acc_valid = 0;
   endtask

   task automatic wr_base(input logic [1:0] sel, input logic [63:0] d, input logic [1:0] pl);
      msr_wr_valid = 1; msr_wr_sel = sel; msr_wr_data = d; cpl = pl;
      step();
      idle(); cpl = 0;
   endtask

   task automatic access(input logic m, input logic [2:0] s, input logic [63:0] ix,
                         input logic [63:0] dp);
      mode64 = m; acc_valid = 1; acc_seg = s; acc_index = ix; acc_disp = dp;
      step();
      idle();
   endtask

   task automatic read_base(input logic [2:0] s, output logic [63:0] v);
      access(1'b1, s, 64'd0, 64'd0);
      v = rsp_addr;
   endtask

   function automatic logic canon(input logic [63:0] a);
      return (a[63:47] == 17'h1FFFF) || (a[63:47] == 17'h0);
   endfunction

   task automatic t_reset();
      logic [63:0] v;
      check("R1 rsp_valid after reset", {63'd0, rsp_valid}, 64'd0);
      read_base(3'd4, v); check("R1 FS reset", v, 64'd0);
      read_base(3'd5, v); check("R1 GS reset", v, 64'd0);
      swap_req = 1; mode64 = 1; step(); idle();
      read_base(3'd5, v); check("R1 kernel shadow reset", v, 64'd0);
   endtask

   task automatic t_zero_base();
      logic [63:0] e;
      leg_base = 32'hDEAD_BEEF;
      for (int s = 0; s < 4; s++) begin
         e = 64'h0000_1234_0000_0010 + 64'hFFFF_FFFF_FFFF_FFF0;
         access(1'b1, 3'(s), 64'h0000_1234_0000_0010, 64'hFFFF_FFFF_FFFF_FFF0);
         check("R2 zero base in 64-bit", rsp_addr, e);
         check("R2 no fault", {62'd0, rsp_code}, 64'd0);
      end
   endtask

   task automatic t_fs_gs_wrap();
      logic [63:0] b, e;
      b = 64'hFFFF_FFFF_FFFF_F000;
      wr_base(2'd0, b, 2'd0);
      e = b + 64'h0000_0000_0000_2000 + 64'h10;
      access(1'b1, 3'd4, 64'h2000, 64'h10);
      check("R3 FS wraps to positive", rsp_addr, e);
      check("R3 FS no fault", {62'd0, rsp_code}, 64'd0);
      wr_base(2'd1, 64'h0000_0000_1000_0000, 2'd0);
      e = 64'h1000_0000 + 64'h20 + 64'hFFFF_FFFF_FFFF_FFFF;
      access(1'b1, 3'd5, 64'h20, 64'hFFFF_FFFF_FFFF_FFFF);
      check("R3 GS base+index+disp", rsp_addr, e);
   endtask

   task automatic t_noncanon();
      logic [63:0] a [3];
      a[0] = 64'h0000_8000_0000_0000;
      a[1] = 64'hFFFF_7FFF_FFFF_FFFF;
      a[2] = 64'h0000_7FFF_FFFF_FFFF;
      for (int i = 0; i < 3; i++) begin
         access(1'b1, 3'd3, a[i], 64'd0);
         check("R4 access fault bit", {63'd0, rsp_code[0]}, {63'd0, !canon(a[i])});
         check("R4 address reported", rsp_addr, a[i]);
      end
   endtask

   task automatic t_seg_load();
      logic [63:0] v;
      wr_base(2'd1, 64'hFFFF_FFFF_1234_5678, 2'd0);
      seg_ld_valid = 1; seg_ld_sel = 1; seg_ld_base = 32'hCAFE_0000; step(); idle();
      read_base(3'd5, v); check("R5 GS load clears upper", v, 64'h0000_0000_CAFE_0000);
      seg_ld_valid = 1; seg_ld_sel = 0; seg_ld_base = 32'h8000_0004; step(); idle();
      read_base(3'd4, v); check("R5 FS load", v, 64'h0000_0000_8000_0004);
   endtask

   task automatic t_priv_write();
      logic [63:0] v;
      wr_base(2'd0, 64'h0000_1111_2222_3333, 2'd0);
      check("R6 good write valid", {63'd0, rsp_valid}, 64'd1);
      check("R6 good write code", {62'd0, rsp_code}, 64'd0);
      read_base(3'd4, v); check("R6 full width loaded", v, 64'h0000_1111_2222_3333);
      wr_base(2'd0, 64'h0000_0000_0000_0042, 2'd3);
      check("R6 cpl3 rejected", {62'd0, rsp_code}, 64'd2);
      read_base(3'd4, v); check("R6 cpl3 unchanged", v, 64'h0000_1111_2222_3333);
      wr_base(2'd0, 64'h0001_0000_0000_0000, 2'd0);
      check("R6 non-canonical rejected", {63'd0, rsp_fault}, 64'd1);
      read_base(3'd4, v); check("R6 non-canonical unchanged", v, 64'h0000_1111_2222_3333);
      wr_base(2'd3, 64'h5, 2'd0);
      check("R6 bad selector rejected", {62'd0, rsp_code}, 64'd2);
      read_base(3'd4, v); check("R6 bad selector FS unchanged", v, 64'h0000_1111_2222_3333);
   endtask

   task automatic t_swap();
      logic [63:0] v;
      wr_base(2'd1, 64'h0000_0000_AAAA_0000, 2'd0);
      wr_base(2'd2, 64'hFFFF_8000_BBBB_0000, 2'd0);
      mode64 = 1; swap_req = 1; step(); idle();
      read_base(3'd5, v); check("R7 GS takes shadow", v, 64'hFFFF_8000_BBBB_0000);
      mode64 = 0; swap_req = 1; step(); idle();
      read_base(3'd5, v); check("R7 swap ignored in compat", v, 64'hFFFF_8000_BBBB_0000);
      swap_req = 1; step(); idle();
      read_base(3'd5, v); check("R7 swap back", v, 64'h0000_0000_AAAA_0000);
   endtask

   task automatic t_compat();
      logic [31:0] e;
      wr_base(2'd0, 64'hFFFF_FFFF_8000_0010, 2'd0);
      e = 32'h8000_0010 + 32'hFFFF_FFF0 + 32'h0000_0100;
      access(1'b0, 3'd4, 64'h1234_5678_FFFF_FFF0, 64'h0000_0100);
      check("R8 FS compat 32-bit", rsp_addr, {32'd0, e});
      check("R8 compat no fault", {62'd0, rsp_code}, 64'd0);
      leg_base = 32'hF000_0000;
      e = 32'hF000_0000 + 32'h2000_0000 + 32'h0000_0004;
      access(1'b0, 3'd3, 64'hFFFF_0000_2000_0000, 64'h4);
      check("R8 DS compat uses leg_base", rsp_addr, {32'd0, e});
   endtask

   task automatic t_mode_switch();
      logic [63:0] v;
      wr_base(2'd0, 64'hFFFF_C000_0000_1000, 2'd0);
      for (int k = 0; k < 4; k++) begin
         mode64 = k[0]; step();
      end
      read_base(3'd4, v); check("R9 FS survives mode toggles", v, 64'hFFFF_C000_0000_1000);
   endtask

   task automatic t_priority();
      logic [63:0] v;
      wr_base(2'd1, 64'h100, 2'd0);
      wr_base(2'd2, 64'h200, 2'd0);
      wr_base(2'd0, 64'h300, 2'd0);
      mode64 = 1; swap_req = 1;
      msr_wr_valid = 1; msr_wr_sel = 2'd0; msr_wr_data = 64'h999;
      seg_ld_valid = 1; seg_ld_sel = 0; seg_ld_base = 32'h777;
      step(); idle();
      check("R10 losing write gives no response", {63'd0, rsp_valid}, 64'd0);
      read_base(3'd4, v); check("R10 FS untouched under swap", v, 64'h300);
      read_base(3'd5, v); check("R10 swap done", v, 64'h200);
      msr_wr_valid = 1; msr_wr_sel = 2'd1; msr_wr_data = 64'h444;
      seg_ld_valid = 1; seg_ld_sel = 1; seg_ld_base = 32'h555;
      step(); idle();
      read_base(3'd5, v); check("R10 write beats load", v, 64'h444);
   endtask

   task automatic t_same_cycle();
      logic [63:0] v;
      wr_base(2'd1, 64'h1000, 2'd0);
      mode64 = 1; acc_valid = 1; acc_seg = 3'd5; acc_index = 64'h0000_7FFF_FFFF_F000;
      acc_disp = 64'h1000;
      msr_wr_valid = 1; msr_wr_sel = 2'd1; msr_wr_data = 64'h8; cpl = 2'd1;
      step(); idle(); cpl = 0;
      check("R11 both faults", {62'd0, rsp_code}, 64'd3);
      check("R11 address with rejected write", rsp_addr, 64'h0000_8000_0000_1000);
      acc_valid = 1; acc_seg = 3'd5; acc_index = 64'd0; acc_disp = 64'd0;
      msr_wr_valid = 1; msr_wr_sel = 2'd1; msr_wr_data = 64'h2000;
      step(); idle();
      check("R11 access sees old GS", rsp_addr, 64'h1000);
      read_base(3'd5, v); check("R11 new GS next cycle", v, 64'h2000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      t_reset();
      t_zero_base();
      t_fs_gs_wrap();
      t_noncanon();
      t_seg_load();
      t_priv_write();
      t_swap();
      t_compat();
      t_mode_switch();
      t_priority();
      t_same_cycle();
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      #(5.0 * 200000);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule